// File: doc/BRIEF.md
# Packed Horizontal Add Unit

This execution unit belongs to a 32-bit DSP datapath. It splits one 32-bit source word into four unsigned byte lanes and adds those lanes together inside the same word, rather than pairing them with lanes of a second register. Two per-lane masks shape the sum. One mask decides which lanes are included. The other decides which included lanes are doubled (shifted left by one) before the addition. The total is clamped to the byte range and written zero-extended into a 32-bit result. These within-word reductions are useful in pixel filters and predictors, where neighbouring samples packed into one register need weighted sums.

A second operation on the same unit adds two full 32-bit operands and shifts the sum right by a small immediate. Software uses it for rounded averages: the rounding offset is placed in one operand and the shift does the division. Every operation is issued with a valid strobe. Its result appears in an output register on the next clock edge.

Top module: `packed_hadd`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to zero at that edge.
- R2: `out_valid` is high in exactly the cycle after an edge that captured `in_valid` high with `rst` low, so back-to-back issues give back-to-back results.
- R3: Opcode 2'b00 (plain) sums all four unsigned lanes of `src_a`, where lane i is bits 8i+7:8i. Both masks and `src_b` are ignored.
- R4: Opcode 2'b01 (single mask) sums all four lanes and doubles lane i when `dbl_mask[i]` is 1. `add_mask` is ignored.
- R5: Opcode 2'b10 (dual mask) sums only the lanes whose `add_mask` bit is 1, and doubles those lanes whose `dbl_mask` bit is also 1. A `dbl_mask` bit on an excluded lane has no effect.
- R6: For the three reduce opcodes, a sum above 255 is clamped to 255. The internal sum is wide enough that the largest case, four doubled lanes of 255, does not wrap.
- R7: For the three reduce opcodes, `result[31:8]` is zero.
- R8: Opcode 2'b11 (add-round) forms the 33-bit sum `src_a + src_b`, shifts it right by `shamt` (0 to 7) and returns the low 32 bits. With `shamt` 0, the carry out of bit 31 is dropped.
- R9: An edge with `in_valid` low and `rst` low leaves `result` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the current operands |
| op | input | 2 | Operation select (00 plain, 01 single mask, 10 dual mask, 11 add-round) |
| add_mask | input | 4 | Lane inclusion mask, bit i for lane i (dual-mask form only) |
| dbl_mask | input | 4 | Lane doubling mask, bit i for lane i |
| shamt | input | 3 | Right-shift amount for add-round |
| src_a | input | 32 | Packed source word / first add-round operand |
| src_b | input | 32 | Second add-round operand |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 32 | Registered result |

## Verification
The bench targets lane sums that land just on either side of 255. A narrow accumulator or a missing clamp would wrap them, for example 256 coming out as 0. It checks that a doubling bit on an excluded lane is ignored; a design that doubled before masking would add that lane back into the sum. It also checks that the plain and single-mask forms ignore `add_mask`; a shared decoder that leaked that mask would drop lanes. On the add-round side, it carries out of bit 31 with shifts of 0 and 1, so a design with a 32-bit adder would lose the top bit. Finally, it changes the operands while the strobe is low, which catches a result register that loads without being enabled.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN   = 2'b00,
    OP_ONEMASK = 2'b01,
    OP_TWOMASK = 2'b10,
    OP_ADDRND  = 2'b11
  } hadd_op_e;
endpackage

// File: rtl/hadd_lane_term.sv
// One lane's contribution: zero when excluded, the lane or twice the lane otherwise.
module hadd_lane_term #(
  parameter int LANE_W = 8,
  parameter int TERM_W = 9
) (
  input  logic [LANE_W-1:0] lane,
  input  logic              take,
  input  logic              dbl,
  output logic [TERM_W-1:0] term
);
  always_comb begin
    if (!take)    term = '0;
    else if (dbl) term = TERM_W'({lane, 1'b0});
    else          term = TERM_W'(lane);
  end
endmodule

// File: rtl/hadd_reduce.sv
// Masked lane reduction with clamping to the lane range.
module hadd_reduce #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int SUM_W  = LANE_W + 1 + $clog2(LANES)
) (
  input  logic [LANES*LANE_W-1:0] word,
  input  logic [LANES-1:0]        take,
  input  logic [LANES-1:0]        dbl,
  output logic [LANE_W-1:0]       sat
);
  localparam int TERM_W = LANE_W + 1;
  localparam logic [SUM_W-1:0] LIM = SUM_W'({LANE_W{1'b1}});

  logic [TERM_W-1:0] terms [LANES];
  logic [SUM_W-1:0]  acc;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hadd_lane_term #(.LANE_W(LANE_W), .TERM_W(TERM_W)) u_term (
      .lane (word[g*LANE_W +: LANE_W]),
      .take (take[g]),
      .dbl  (dbl[g]),
      .term (terms[g])
    );
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + SUM_W'(terms[i]);
  end

  assign sat = (acc > LIM) ? {LANE_W{1'b1}} : acc[LANE_W-1:0];
endmodule

// File: rtl/hadd_addrnd.sv
// Full-width add followed by a logical right shift of the carry-extended sum.
module hadd_addrnd #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W:0] sum;
  logic [DATA_W:0] shifted;

  assign sum     = {1'b0, a} + {1'b0, b};
  assign shifted = sum >> sh;
  assign res     = shifted[DATA_W-1:0];
endmodule

// File: rtl/packed_hadd.sv
module packed_hadd #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int SH_W   = 3,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [LANES-1:0]  add_mask,
  input  logic [LANES-1:0]  dbl_mask,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import hadd_pkg::*;

  localparam int SUM_W = LANE_W + 1 + $clog2(LANES);

  hadd_op_e          opc;
  logic [LANES-1:0]  take;
  logic [LANES-1:0]  dbl;
  logic [LANE_W-1:0] sat;
  logic [DATA_W-1:0] rnd;

  assign opc = hadd_op_e'(op);

  // Mask decode: plain and single-mask forms include every lane.
  always_comb begin
    unique case (opc)
      OP_PLAIN:   begin take = '1;       dbl = '0;       end
      OP_ONEMASK: begin take = '1;       dbl = dbl_mask; end
      OP_TWOMASK: begin take = add_mask; dbl = dbl_mask; end
      default:    begin take = '0;       dbl = '0;       end
    endcase
  end

  hadd_reduce #(.LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_reduce (
    .word (src_a),
    .take (take),
    .dbl  (dbl),
    .sat  (sat)
  );

  hadd_addrnd #(.DATA_W(DATA_W), .SH_W(SH_W)) u_addrnd (
    .a   (src_a),
    .b   (src_b),
    .sh  (shamt),
    .res (rnd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= (opc == OP_ADDRND) ? rnd : DATA_W'(sat);
    end
  end
endmodule

// File: rtl/packed_hadd_chk.sv
module packed_hadd_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int SH_W   = 3,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [LANES-1:0]  add_mask,
  input logic [LANES-1:0]  dbl_mask,
  input logic [SH_W-1:0]   shamt,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == ($past(in_valid) && !$past(rst)));

  // R7
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'b11) |=> (result[DATA_W-1:LANE_W] == '0));

  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && src_a[LANE_W-1] && src_a[2*LANE_W-1])
      |=> (result == DATA_W'({LANE_W{1'b1}})));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

bind packed_hadd packed_hadd_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .SH_W(SH_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .add_mask(add_mask),
  .dbl_mask(dbl_mask), .shamt(shamt), .src_a(src_a), .src_b(src_b),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_packed_hadd.sv
module tb_packed_hadd;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [3:0]  add_mask = 4'h0;
  logic [3:0]  dbl_mask = 4'h0;
  logic [2:0]  shamt = 3'd0;
  logic [31:0] src_a = 32'h0;
  logic [31:0] src_b = 32'h0;
  logic        out_valid;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  packed_hadd dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .add_mask(add_mask),
    .dbl_mask(dbl_mask), .shamt(shamt), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  // {op, add_mask, dbl_mask, shamt, src_a, src_b, expected}
  localparam int NV = 17;
  localparam logic [108:0] VEC [NV] = '{
    {2'd0, 4'h0, 4'h0, 3'd0, 32'h01020304, 32'h00000000, 32'h0000000A}, // R3
    {2'd0, 4'hF, 4'hF, 3'd0, 32'h40302010, 32'h00000000, 32'h000000A0}, // R3 masks ignored
    {2'd0, 4'h0, 4'h0, 3'd0, 32'hFF000001, 32'h00000000, 32'h000000FF}, // R6 sum 256
    {2'd0, 4'h0, 4'h0, 3'd0, 32'h00000000, 32'h00000000, 32'h00000000}, // R3
    {2'd0, 4'h0, 4'h0, 3'd0, 32'h01010101, 32'hFFFFFFFF, 32'h00000004}, // R3 src_b ignored
    {2'd1, 4'h0, 4'h1, 3'd0, 32'h01020304, 32'h00000000, 32'h0000000E}, // R4
    {2'd1, 4'hF, 4'h8, 3'd0, 32'h01020304, 32'h00000000, 32'h0000000B}, // R4
    {2'd1, 4'h0, 4'hF, 3'd0, 32'h20202020, 32'h00000000, 32'h000000FF}, // R6 sum 256
    {2'd1, 4'h0, 4'hF, 3'd0, 32'hFFFFFFFF, 32'h00000000, 32'h000000FF}, // R6 sum 2040
    {2'd2, 4'h3, 4'h1, 3'd0, 32'h01020304, 32'h00000000, 32'h0000000B}, // R5
    {2'd2, 4'h4, 4'hB, 3'd0, 32'h01020304, 32'h00000000, 32'h00000002}, // R5 dbl on excluded lanes
    {2'd2, 4'h0, 4'hF, 3'd0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000}, // R5 nothing selected
    {2'd2, 4'h9, 4'h9, 3'd0, 32'h7F00007F, 32'h00000000, 32'h000000FF}, // R6 sum 508
    {2'd3, 4'h0, 4'h0, 3'd2, 32'h00000010, 32'h00000002, 32'h00000004}, // R8
    {2'd3, 4'h0, 4'h0, 3'd1, 32'hFFFFFFFF, 32'h00000001, 32'h80000000}, // R8 carry kept
    {2'd3, 4'h0, 4'h0, 3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R8 carry dropped
    {2'd3, 4'h0, 4'h0, 3'd4, 32'h12345678, 32'h11111111, 32'h02345678}  // R8
  };

  function automatic string vec_tag(int i);
    if (i < 5)        return "R3";
    else if (i < 9)   return "R4/R6";
    else if (i < 13)  return "R5/R6";
    else              return "R8";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    rst = 1'b0;

    // Table walk, issued back to back (R2)
    for (int i = 0; i < NV; i++) begin
      op       = VEC[i][108:107];
      add_mask = VEC[i][106:103];
      dbl_mask = VEC[i][102:99];
      shamt    = VEC[i][98:96];
      src_a    = VEC[i][95:64];
      src_b    = VEC[i][63:32];
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R2 out_valid", {31'd0, out_valid}, 32'd1);
      check(vec_tag(i), result, VEC[i][31:0]);
    end

    // R9: strobe low, operands change, result holds
    held     = result;
    in_valid = 1'b0;
    op       = 2'b00;
    src_a    = 32'h05050505;
    @(posedge clk);
    @(negedge clk);
    check("R9 result hold", result, held);
    check("R2 out_valid low", {31'd0, out_valid}, 32'd0);

    // R7: reduce result upper bits zero with a full source word
    op = 2'b01; dbl_mask = 4'h0; src_a = 32'h00000703; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 zero-extended", result, 32'h0000000A);

    // R1: reset in the middle of an issue clears the outputs
    rst = 1'b1;
    op = 2'b11; src_a = 32'h11111111; src_b = 32'h0; shamt = 3'd0;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run result", result, 32'd0);
    check("R1 mid-run out_valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule